// File: doc/BRIEF.md
# Hybrid Coarse/Fine Digital Pulse Width Modulator

This block produces one pulse-width-modulated output whose edge placement is four times finer than its counter clock. A free-running counter on the reference phase counts whole clock cycles for the upper bits of the duty command. The two lowest duty bits then pick one of four quarter-period clock phases, and the edge of that phase ends the pulse. This adds zero to three quarter periods to the pulse after the coarse part has run out. The four phases (0°, 90°, 180° and 270° relative to the reference) are inputs. They come from a clock manager outside the block, which in typical use multiplies a slower reference up to the counter rate, for example 32 MHz up to 128 MHz.

The switching period is 2^(DUTY_W-2) reference cycles. The coarse stage therefore resolves the clock-to-switching frequency ratio, and the phase stage multiplies that resolution by four. The duty command is captured once per period, at the reference edge that starts it. A command that changes inside a period therefore reshapes nothing until the next period begins. The pulse width in quarter periods equals the duty code for every code except the all-ones code, which holds the output high.

Top module: `hrpwm_hybrid`

## Requirements
- R1: While rst_n is low, pwm_o is low. After rst_n rises, the first rising edge of clk_ph[0] starts a period that uses the duty_i value present at that edge.
- R2: Each period lasts exactly 2^(DUTY_W-2) cycles of clk_ph[0]. A new period starts at every such rising edge, counted from the first edge after reset.
- R3: For a duty code whose upper bits duty_i[DUTY_W-1:2] equal C, pwm_o is high for the first C full cycles of the period. This holds for every code except all-ones.
- R4: The low bits duty_i[1:0] = k extend the pulse by k quarter periods past the coarse part, ending it on the rising edge of clk_ph[k]. For k = 0 there is no extension. Once the pulse has ended, pwm_o stays low for the rest of the period.
- R5: For every code from 0 to 2^DUTY_W-2, the high time per period equals the duty code in quarter periods of clk_ph[0]. Each pulse starts at the period start.
- R6: A duty code of zero keeps pwm_o low for the whole period.
- R7: The all-ones duty code keeps pwm_o high for the whole period, with no low gap at the period boundary.
- R8: duty_i is sampled only at the rising edge of clk_ph[0] that starts a period. A change at any other time leaves the current period's width unchanged and takes effect at the next period.
- R9: The high time never decreases as the duty code increases.
- R10: A pulse that ends inside the last cycle of one period does not suppress a short pulse at the start of the next period. A following code of 1 to 3 still yields 1 to 3 quarter periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ph | input | 4 | Clock phases; bit k lags bit 0 by k quarter periods, bit 0 drives the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_i | input | DUTY_W | Duty command in quarter-period units |
| pwm_o | output | 1 | Modulated output |

## Verification
The bench measures the high time of every duty code by sampling the output once in the middle of each quarter period across a whole period. A design that picks the wrong phase, or ends the pulse one phase late, shows up as an off-by-one width on the codes with non-zero low bits. Four corner cases get their own tests:

- **Boundary case.** A pulse that ends in the final counter cycle is followed by a one-quarter pulse. A design that lets a stale phase sample leak across the boundary loses that short pulse.
- **Duty change mid-window.** The duty command is changed halfway through a measured window. A design that reloads the command early produces a width between the old and new codes.
- **Extreme codes.** The all-ones and zero codes are held for two periods. A design without the all-ones override shows a one-quarter notch at each boundary.
- **Reset.** Reset is asserted while the output is high. A design with a synchronous or missing reset path leaves the output high.

// File: rtl/hrpwm_pkg.sv
`timescale 1ns/1ps
package hrpwm_pkg;

    // Number of duty bits resolved by clock phase selection.
    localparam int FINE_W = 2;
    // Number of equally spaced clock phases, reference included.
    localparam int PHASES = 1 << FINE_W;

    // Marker handed from the reference domain to each phase domain:
    // tail is high during the cycle in which the pulse must end,
    // tag flips at every period start so stale samples can be told apart.
    typedef struct packed {
        logic tail;
        logic tag;
    } mark_t;

endpackage

// File: rtl/hrpwm_coarse_stage.sv
`timescale 1ns/1ps
module hrpwm_coarse_stage
    import hrpwm_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DUTY_W-1:0]          duty_i,
    output logic [DUTY_W-FINE_W-1:0]   cnt_o,
    output logic [DUTY_W-1:0]          duty_lat_o,
    output logic                       on_o,
    output logic                       full_o,
    output logic [FINE_W-1:0]          fine_o,
    output mark_t                      mark_o
);

    localparam int CNT_W = DUTY_W - FINE_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DUTY_W-1:0] duty;
        logic              on;
        logic              tail;
        logic              tag;
        logic              full;
    } state_t;

    state_t st_d, st_q;
    logic [CNT_W-1:0]  coarse_d;
    logic [FINE_W-1:0] fine_d;

    // Next-state: counter wraps at the period end, the command is
    // captured only on the wrap, and the coarse window, the closing
    // cycle and the saturation flag are decoded for the new count.
    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(1);
        if (st_q.cnt == CNT_MAX) begin
            st_d.duty = duty_i;
            st_d.tag  = ~st_q.tag;
        end
        coarse_d  = st_d.duty[DUTY_W-1:FINE_W];
        fine_d    = st_d.duty[FINE_W-1:0];
        st_d.full = &st_d.duty;
        st_d.on   = (st_d.cnt < coarse_d);
        st_d.tail = (st_d.cnt == coarse_d) && (fine_d != '0) && !st_d.full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: CNT_MAX, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o       = st_q.cnt;
    assign duty_lat_o  = st_q.duty;
    assign on_o        = st_q.on;
    assign full_o      = st_q.full;
    assign fine_o      = st_q.duty[FINE_W-1:0];
    assign mark_o.tail = st_q.tail;
    assign mark_o.tag  = st_q.tag;

endmodule

// File: rtl/hrpwm_phase_cut.sv
`timescale 1ns/1ps
module hrpwm_phase_cut
    import hrpwm_pkg::*;
(
    input  logic  clk_phase,
    input  logic  rst_n,
    input  mark_t mark_i,
    output logic  cut_o
);

    typedef struct packed {
        mark_t seen;
    } samp_t;

    samp_t samp_d, samp_q;

    // Capture the reference-domain marker on this phase's edge.
    always_comb begin
        samp_d      = samp_q;
        samp_d.seen = mark_i;
    end

    always_ff @(posedge clk_phase or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
        end else begin
            samp_q <= samp_d;
        end
    end

    // The cut is valid only for a sample taken in the current period:
    // a sample left over from the previous period carries the old tag.
    assign cut_o = samp_q.seen.tail & (samp_q.seen.tag == mark_i.tag);

endmodule

// File: rtl/hrpwm_edge_merge.sv
`timescale 1ns/1ps
module hrpwm_edge_merge
    import hrpwm_pkg::*;
(
    input  logic              on_i,
    input  logic              full_i,
    input  logic              tail_i,
    input  logic [FINE_W-1:0] fine_i,
    input  logic [PHASES-1:0] cut_i,
    output logic              pwm_o
);

    logic cut_sel;

    // cut_i[0] is tied high by the parent, so a zero fine field
    // never opens the closing cycle.
    always_comb begin
        cut_sel = cut_i[fine_i];
        pwm_o   = full_i | on_i | (tail_i & ~cut_sel);
    end

endmodule

// File: rtl/hrpwm_hybrid.sv
`timescale 1ns/1ps
module hrpwm_hybrid
    import hrpwm_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic [3:0]        clk_ph,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o
);

    localparam int CNT_W = DUTY_W - FINE_W;

    logic [CNT_W-1:0]  cnt_w;
    logic [DUTY_W-1:0] duty_lat_w;
    logic              on_w;
    logic              full_w;
    logic [FINE_W-1:0] fine_w;
    mark_t             mark_w;
    logic [PHASES-1:0] cut_w;

    hrpwm_coarse_stage #(
        .DUTY_W (DUTY_W)
    ) u_coarse (
        .clk        (clk_ph[0]),
        .rst_n      (rst_n),
        .duty_i     (duty_i),
        .cnt_o      (cnt_w),
        .duty_lat_o (duty_lat_w),
        .on_o       (on_w),
        .full_o     (full_w),
        .fine_o     (fine_w),
        .mark_o     (mark_w)
    );

    assign cut_w[0] = 1'b1;

    for (genvar k = 1; k < PHASES; k++) begin : g_phase
        hrpwm_phase_cut u_cut (
            .clk_phase (clk_ph[k]),
            .rst_n     (rst_n),
            .mark_i    (mark_w),
            .cut_o     (cut_w[k])
        );
    end

    hrpwm_edge_merge u_merge (
        .on_i   (on_w),
        .full_i (full_w),
        .tail_i (mark_w.tail),
        .fine_i (fine_w),
        .cut_i  (cut_w),
        .pwm_o  (pwm_o)
    );

endmodule

// File: rtl/hrpwm_hybrid_checker.sv
`timescale 1ns/1ps
module hrpwm_hybrid_checker
    import hrpwm_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input logic                     clk_ref,
    input logic                     clk_q1,
    input logic                     rst_n,
    input logic                     pwm,
    input logic [DUTY_W-FINE_W-1:0] cnt,
    input logic [DUTY_W-1:0]        duty_lat
);

    localparam int CNT_W = DUTY_W - FINE_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]  coarse;
    logic [FINE_W-1:0] fine;
    logic              full;

    assign coarse = duty_lat[DUTY_W-1:FINE_W];
    assign fine   = duty_lat[FINE_W-1:0];
    assign full   = &duty_lat;

    always @(posedge clk_ref) begin
        if (!rst_n) begin
            assert_reset_low_R1: assert (pwm == 1'b0)
                else $error("output high during reset");
        end
    end

    assert_period_wrap_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cnt == '0))
        else $error("counter did not wrap at period end");

    assert_coarse_high_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cnt < coarse) |-> pwm)
        else $error("output low inside coarse window");

    assert_after_end_low_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ((cnt >= coarse) && !full) |-> !pwm)
        else $error("output still high after pulse end");

    assert_closing_head_R10: assert property (@(posedge clk_q1) disable iff (!rst_n)
        ((cnt == coarse) && (fine != '0) && !full) |-> pwm)
        else $error("closing cycle lost its first quarter");

    assert_zero_low_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (duty_lat == '0) |-> !pwm)
        else $error("zero code produced a pulse");

    assert_full_high_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        full |-> pwm)
        else $error("all-ones code produced a gap");

    assert_cmd_hold_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cnt != '0) |-> $stable(duty_lat))
        else $error("command reloaded mid-period");

endmodule

bind hrpwm_hybrid hrpwm_hybrid_checker #(
    .DUTY_W (DUTY_W)
) u_chk (
    .clk_ref  (clk_ph[0]),
    .clk_q1   (clk_ph[1]),
    .rst_n    (rst_n),
    .pwm      (pwm_o),
    .cnt      (cnt_w),
    .duty_lat (duty_lat_w)
);

// File: tb/sim_hrpwm_hybrid.sv
`timescale 1ns/100ps
module sim_hrpwm_hybrid;

    localparam int DUTY_W = 8;
    localparam int PER    = 1 << (DUTY_W - 2);
    localparam int Q      = 4 * PER;
    localparam int NVEC   = 12;
    localparam int WD_NS  = 3000000;

    // {duty code, expected high quarters}
    localparam int VEC [NVEC][2] = '{
        '{0, 0}, '{1, 1}, '{2, 2}, '{3, 3}, '{4, 4}, '{5, 5},
        '{127, 127}, '{128, 128}, '{200, 200}, '{252, 252},
        '{254, 254}, '{255, 256}
    };

    logic [3:0]        clk_ph;
    logic              rst_n;
    logic [DUTY_W-1:0] duty;
    logic              pwm;
    int                edge_n;
    int                n_cmp;
    int                n_bad;
    bit                done;

    hrpwm_hybrid #(.DUTY_W(DUTY_W)) u0 (
        .clk_ph (clk_ph),
        .rst_n  (rst_n),
        .duty_i (duty),
        .pwm_o  (pwm)
    );

    // 50 MHz reference, each further phase a quarter period later.
    initial begin clk_ph[0] = 1'b0; #10; forever #10 clk_ph[0] = ~clk_ph[0]; end
    initial begin clk_ph[1] = 1'b0; #15; forever #10 clk_ph[1] = ~clk_ph[1]; end
    initial begin clk_ph[2] = 1'b0; #20; forever #10 clk_ph[2] = ~clk_ph[2]; end
    initial begin clk_ph[3] = 1'b0; #25; forever #10 clk_ph[3] = ~clk_ph[3]; end

    always @(posedge clk_ph[0] or negedge rst_n) begin
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Return 1 ns after the next reference edge that starts a period.
    task automatic wait_start();
        do begin
            @(posedge clk_ph[0]);
            #1;
        end while (((edge_n - 1) % PER) != 0);
    endtask

    // Called 1 ns after a period start; samples mid-quarter over the
    // whole period, optionally changing the command at one sample,
    // and returns 1 ns after the following period start.
    task automatic measure(input int chg_at, input logic [DUTY_W-1:0] chg_val,
                           output int w);
        w = 0;
        #1.5;
        for (int j = 0; j < Q; j++) begin
            if (j == chg_at) duty = chg_val;
            if (pwm) w++;
            if (j != Q - 1) #5;
        end
        @(posedge clk_ph[0]);
        #1;
    endtask

    task automatic run_code(input logic [DUTY_W-1:0] d, output int w);
        wait_start();
        duty = d;
        wait_start();
        measure(-1, '0, w);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(WD_NS);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int w;
        int prev;
        int highs;
        n_cmp = 0;
        n_bad = 0;
        done  = 1'b0;
        duty  = '1;
        rst_n = 1'b1;
        #1 rst_n = 1'b0;

        // R1: output low throughout reset even with the all-ones code.
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            #5;
            if (pwm) highs++;
        end
        check("R1 reset low", highs, 0);

        // R1: first period after release uses the command at that edge.
        duty = 8'd100;
        @(posedge clk_ph[0]);
        #2.5 rst_n = 1'b1;
        wait_start();
        measure(-1, '0, w);
        check("R1 first period", w, 100);

        // Vector table: R3, R4, R5, R6, R7.
        for (int v = 0; v < NVEC; v++) begin
            run_code(DUTY_W'(VEC[v][0]), w);
            check($sformatf("R5 table code %0d", VEC[v][0]), w, VEC[v][1]);
        end

        // Full sweep: R2 period length, R5 width per code, R9 monotonic.
        prev = -1;
        for (int d = 0; d < (1 << DUTY_W); d++) begin
            run_code(DUTY_W'(d), w);
            check($sformatf("R5 sweep code %0d", d), w,
                  (d == (1 << DUTY_W) - 1) ? Q : d);
            check($sformatf("R9 monotonic code %0d", d), int'(w >= prev), 1);
            prev = w;
        end

        // R4: each low-bit value adds exactly one quarter over coarse 10.
        for (int k = 0; k < 4; k++) begin
            run_code(DUTY_W'(40 + k), w);
            check($sformatf("R4 fine step %0d", k), w, 40 + k);
        end

        // R8: change mid-window is ignored, then applied next period.
        wait_start();
        duty = 8'd60;
        wait_start();
        measure(Q / 2, 8'd200, w);
        check("R8 mid-period hold", w, 60);
        measure(-1, '0, w);
        check("R8 next period", w, 200);

        // R10: pulse ending in last cycle, then short pulses.
        wait_start();
        duty = 8'd253;
        wait_start();
        duty = 8'd1;
        measure(-1, '0, w);
        check("R10 long pulse", w, 253);
        duty = 8'd254;
        measure(-1, '0, w);
        check("R10 short after long", w, 1);
        duty = 8'd2;
        measure(-1, '0, w);
        check("R10 long pulse 2", w, 254);
        duty = 8'd251;
        measure(-1, '0, w);
        check("R10 short after long 2", w, 2);
        duty = 8'd3;
        measure(-1, '0, w);
        check("R10 long pulse 3", w, 251);
        measure(-1, '0, w);
        check("R10 short after long 3", w, 3);

        // R7 and R6: two consecutive periods at each extreme.
        wait_start();
        duty = '1;
        wait_start();
        measure(-1, '0, w);
        highs = w;
        measure(-1, '0, w);
        check("R7 constant high", highs + w, 2 * Q);
        duty = '0;
        measure(-1, '0, w);
        wait_start();
        measure(-1, '0, w);
        highs = w;
        measure(-1, '0, w);
        check("R6 constant low", highs + w, 0);

        // R1: reset asserted while output high forces it low at once.
        duty = '1;
        wait_start();
        wait_start();
        #3;
        check("R1 high before reset", int'(pwm), 1);
        rst_n = 1'b0;
        #1;
        check("R1 reset forces low", int'(pwm), 0);
        #30;
        check("R1 reset held low", int'(pwm), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule